// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block translates 64-bit virtual addresses to physical addresses through a fully associative table of translation entries. Each slot holds a tag word (the virtual page in the upper bits, a 13-bit address-space context in the low bits) and a translation word that carries a valid flag, a two-bit page size, a privileged-only flag, a writable flag and the physical frame. All slots are compared at once, each under a compare mask set by its own page size. The result is a hit with a physical address and access rights, a miss, or a protection fault.

A fault updates a small sticky status register and captures the faulting address. A status value that is already nonzero when a new fault arrives is replaced by an overflow code before the new fault bits are merged in. A clear strobe empties the status register. When translation is switched off, addresses pass through unchanged with read and write rights. An instruction-mode input suppresses the write-permission check. Slots are loaded through an indexed write port. Each lookup takes one cycle, and all results come from registers.

The response register is a small state machine. Its states are `RS_IDLE` (no request), `RS_PASS` (translation off), `RS_HIT`, `RS_MISS` and `RS_FAULT`. Every clock edge moves it to the state chosen for the request in that cycle. A cycle with no request goes to `RS_IDLE`. A request with translation off goes to `RS_PASS`. With translation on, a request that matches no slot goes to `RS_MISS`. A match that breaks a protection rule goes to `RS_FAULT`, and any other match goes to `RS_HIT`. Reset forces `RS_IDLE`.

Top module: `tlb_xlate`

## Requirements
- R1: The page size field is translation-word bits [62:61]. The encodings 0, 1, 2 and 3 select 8 KB, 64 KB, 512 KB and 4 MB. The compare mask clears the low 13, 16, 19 or 22 address bits, so a page covers exactly its aligned span.
- R2: A slot matches when tag bits [12:0] equal `ctx` and the masked address equals the tag with bits [12:0] cleared.
- R3: When several slots match, the slot with the lowest index decides the result.
- R4: On a hit, `resp_pa` is the sum of two terms, both confined to bits [40:12]. The first is the translation word under the mask. The second is the request address below the mask. Bits [11:0] and [63:41] of `resp_pa` are zero.
- R5: A hit grants `resp_rd`. It grants `resp_wr` only when translation-word bit 1 (writable) is set.
- R6: A matching slot faults in three cases: its bit 63 (valid) is clear; its bit 2 (privileged) is set and `req_user` is high; or the request is a data write (`req_write` high, `req_fetch` low) and bit 1 is clear. With `req_fetch` high, the write check is skipped. A fault grants no rights and gives `resp_pa` = 0.
- R7: A request that matches no slot gives `resp_miss`, no rights and `resp_pa` = 0.
- R8: On a fault, `fsr` becomes ((old `fsr` != 0) ? 2 : 0) OR (user<<3) OR (datawrite<<2) OR 1, and `far` takes the request address.
- R9: With `xlate_en` low, a request returns `resp_pa` equal to the address, with `resp_hit`, `resp_rd` and `resp_wr` all high.
- R10: Results appear one cycle after the request. When there is no request, `resp_valid` and all result flags are low, and exactly one of hit, miss or fault is high whenever `resp_valid` is high.
- R11: A slot written with `wr_en` in a given cycle affects lookups from the next cycle on. A lookup in the same cycle sees the old contents.
- R12: Reset clears every tag and translation word, `fsr`, `far` and `resp_valid`. A cleared slot therefore matches context 0 at page 0 as an invalid entry and faults.
- R13: `stat_clr` without a fault in the same cycle sets `fsr` to 0. A fault in the same cycle merges onto a zero base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable; low means pass-through |
| ctx | input | 13 | Current context |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Virtual address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request is from user mode |
| req_fetch | input | 1 | Instruction mode, skips the write check |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_tag | input | 64 | Tag word to store |
| wr_tte | input | 64 | Translation word to store |
| stat_clr | input | 1 | Clear the fault status register |
| resp_valid | output | 1 | Result present |
| resp_hit | output | 1 | Translation granted (hit or pass-through) |
| resp_miss | output | 1 | No slot matched |
| resp_fault | output | 1 | Protection fault |
| resp_pa | output | 64 | Physical address |
| resp_rd | output | 1 | Read right |
| resp_wr | output | 1 | Write right |
| fsr | output | 4 | Fault status register |
| far | output | 64 | Fault address register |

## Verification
The checks assume that `stat_clr` is applied only in cycles with no request. This is what makes the plain "cleared to zero" check valid. They also assume that inputs are stable around the clock edge and change only between edges, which the stimulus arranges by driving everything on the falling edge. Slot contents are taken to be loaded before they are looked up, except in the one case that deliberately tests a write and a lookup in the same cycle. The stimulus aligns every programmed tag and frame to its page size, apart from a few deliberately unaligned frame bits that the mask must discard.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 64;
    localparam int CTX_W      = 13;
    localparam int FSR_W      = 4;
    localparam int VALID_BIT  = 63;
    localparam int SIZE_HI    = 62;
    localparam int SIZE_LO    = 61;
    localparam int PRIV_BIT   = 2;
    localparam int WRITE_BIT  = 1;
    localparam int PA_HI      = 40;
    localparam int PA_LO      = 12;
    localparam int BASE_SHIFT = 13;
    localparam int SIZE_STEP  = 3;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_PASS,
        RS_HIT,
        RS_MISS,
        RS_FAULT
    } rsp_state_e;

    // Mask that keeps the page number bits for a given size code.
    function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
        int unsigned sh;
        sh = BASE_SHIFT + SIZE_STEP * int'(sz);
        return ~((64'd1 << sh) - 64'd1);
    endfunction

    // Physical frame field [PA_HI:PA_LO].
    function automatic logic [VA_W-1:0] frame_field();
        return ((64'd1 << (PA_HI + 1)) - 64'd1) & ~((64'd1 << PA_LO) - 64'd1);
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_tag,
    input  logic [VA_W-1:0]   wr_tte,
    output logic [VA_W-1:0]   tag_q [NUM_ENTRIES],
    output logic [VA_W-1:0]   tte_q [NUM_ENTRIES]
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[i] <= '0;
                tte_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                tag_q[i] <= wr_tag;
                tte_q[i] <= wr_tte;
            end
        end
    end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64
) (
    input  logic [VA_W-1:0]   addr,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [VA_W-1:0]   tag   [NUM_ENTRIES],
    input  logic [1:0]        psize [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] match
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic [VA_W-1:0] msk;
        logic [VA_W-1:0] page;
        assign msk      = size_mask(psize[i]);
        assign page     = {tag[i][VA_W-1:CTX_W], {CTX_W{1'b0}}};
        assign match[i] = (tag[i][CTX_W-1:0] == ctx) && ((addr & msk) == page);
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] match,
    output logic                   any,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              req_fetch,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_tag,
    input  logic [VA_W-1:0]   wr_tte,
    input  logic              stat_clr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              resp_fault,
    output logic [VA_W-1:0]   resp_pa,
    output logic              resp_rd,
    output logic              resp_wr,
    output logic [FSR_W-1:0]  fsr,
    output logic [VA_W-1:0]   far
);

    localparam logic [VA_W-1:0] FRAME_MASK = frame_field();

    logic [VA_W-1:0]        tag_q [NUM_ENTRIES];
    logic [VA_W-1:0]        tte_q [NUM_ENTRIES];
    logic [1:0]             psize [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;
    logic                   any_match;
    logic [IDX_W-1:0]       sel_idx;
    logic [VA_W-1:0]        sel_tte;
    logic [VA_W-1:0]        sel_mask;
    logic                   data_write;
    logic                   prot_bad;
    logic [VA_W-1:0]        xlat_pa;
    rsp_state_e             rsp_q, rsp_d;
    logic [FSR_W-1:0]       fsr_base;
    logic                   unused_tte_bits;

    tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_tag (wr_tag),
        .wr_tte (wr_tte),
        .tag_q  (tag_q),
        .tte_q  (tte_q)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_size
        assign psize[i] = tte_q[i][SIZE_HI:SIZE_LO];
    end

    tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .addr  (req_addr),
        .ctx   (ctx),
        .tag   (tag_q),
        .psize (psize),
        .match (match)
    );

    tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .match (match),
        .any   (any_match),
        .idx   (sel_idx)
    );

    assign sel_tte    = tte_q[sel_idx];
    assign sel_mask   = size_mask(sel_tte[SIZE_HI:SIZE_LO]);
    assign data_write = req_write && !req_fetch;
    assign prot_bad   = !sel_tte[VALID_BIT]
                      || (sel_tte[PRIV_BIT] && req_user)
                      || (data_write && !sel_tte[WRITE_BIT]);
    assign xlat_pa    = (sel_tte & sel_mask & FRAME_MASK)
                      + (req_addr & ~sel_mask & FRAME_MASK);
    assign unused_tte_bits = ^{sel_tte[60:41], sel_tte[11:3], sel_tte[0]};

    // Next response state.
    always_comb begin
        if (!req_valid)          rsp_d = RS_IDLE;
        else if (!xlate_en)      rsp_d = RS_PASS;
        else if (!any_match)     rsp_d = RS_MISS;
        else if (prot_bad)       rsp_d = RS_FAULT;
        else                     rsp_d = RS_HIT;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= RS_IDLE;
        else        rsp_q <= rsp_d;
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_pa <= '0;
            resp_rd <= 1'b0;
            resp_wr <= 1'b0;
        end else begin
            unique case (rsp_d)
                RS_PASS: begin
                    resp_pa <= req_addr;
                    resp_rd <= 1'b1;
                    resp_wr <= 1'b1;
                end
                RS_HIT: begin
                    resp_pa <= xlat_pa;
                    resp_rd <= 1'b1;
                    resp_wr <= sel_tte[WRITE_BIT];
                end
                RS_IDLE, RS_MISS, RS_FAULT: begin
                    resp_pa <= '0;
                    resp_rd <= 1'b0;
                    resp_wr <= 1'b0;
                end
                default: begin
                    resp_pa <= '0;
                    resp_rd <= 1'b0;
                    resp_wr <= 1'b0;
                end
            endcase
        end
    end

    assign resp_valid = (rsp_q != RS_IDLE);
    assign resp_hit   = (rsp_q == RS_HIT) || (rsp_q == RS_PASS);
    assign resp_miss  = (rsp_q == RS_MISS);
    assign resp_fault = (rsp_q == RS_FAULT);

    // Fault status and address.
    assign fsr_base = stat_clr ? '0 : fsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr <= '0;
            far <= '0;
        end else if (rsp_d == RS_FAULT) begin
            fsr <= ((fsr_base != '0) ? FSR_W'(2) : FSR_W'(0))
                 | {req_user, data_write, 1'b0, 1'b1};
            far <= req_addr;
        end else if (stat_clr) begin
            fsr <= '0;
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlate_en,
    input logic [CTX_W-1:0]  ctx,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_addr,
    input logic              req_write,
    input logic              req_user,
    input logic              req_fetch,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [VA_W-1:0]   wr_tag,
    input logic [VA_W-1:0]   wr_tte,
    input logic              stat_clr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_miss,
    input logic              resp_fault,
    input logic [VA_W-1:0]   resp_pa,
    input logic              resp_rd,
    input logic              resp_wr,
    input logic [FSR_W-1:0]  fsr,
    input logic [VA_W-1:0]   far
);

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_hit, resp_miss, resp_fault}) == 1));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(resp_hit || resp_miss || resp_fault || resp_rd || resp_wr));

    // R10
    req_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R6
    fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (!resp_rd && !resp_wr && resp_pa == '0));

    // R7
    miss_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> (!resp_rd && !resp_wr && resp_pa == '0));

    // R5
    hit_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_rd);

    // R8
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_en) |=> (resp_fault |-> (fsr[0] && far == $past(req_addr))));

    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_en) |=> (resp_hit && resp_rd && resp_wr && resp_pa == $past(req_addr)));

    // R13
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !req_valid) |=> (fsr == '0));

endmodule

bind tlb_xlate tlb_xlate_chk #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (.*);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [12:0] ctx = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_fetch = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0;
    logic [63:0] wr_tte = '0;
    logic        stat_clr = 1'b0;
    logic        resp_valid, resp_hit, resp_miss, resp_fault, resp_rd, resp_wr;
    logic [63:0] resp_pa, far;
    logic [3:0]  fsr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate uut (.*);

    localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] WB = 64'h2;
    localparam logic [63:0] PB = 64'h4;

    // kind: 0 hit, 1 miss, 2 fault
    typedef struct packed {
        logic [63:0] addr;
        logic [12:0] cx;
        logic        wr;
        logic        usr;
        logic        fch;
        logic [1:0]  kind;
        logic [63:0] pa;
        logic        wperm;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{64'h4000_0abc, 13'd5, 1'b0, 1'b1, 1'b0, 2'd0, 64'h1_2345_6000, 1'b1}, // R1 R2 R3 R4
        '{64'h4000_1fff, 13'd5, 1'b1, 1'b1, 1'b0, 2'd0, 64'h1_2345_7000, 1'b1}, // R5
        '{64'h4000_2000, 13'd5, 1'b0, 1'b0, 1'b0, 2'd1, 64'h0,           1'b0}, // R1 8K edge
        '{64'h8001_7abc, 13'd5, 1'b0, 1'b1, 1'b0, 2'd0, 64'hAB_7000,     1'b0}, // R1 64K
        '{64'h8001_ffff, 13'd5, 1'b0, 1'b1, 1'b0, 2'd0, 64'hAB_F000,     1'b0}, // R4
        '{64'h8002_0000, 13'd5, 1'b0, 1'b1, 1'b0, 2'd1, 64'h0,           1'b0}, // R7 64K edge
        '{64'h8001_7abc, 13'd5, 1'b1, 1'b1, 1'b0, 2'd2, 64'h0,           1'b0}, // R6 write RO
        '{64'h8001_7abc, 13'd5, 1'b1, 1'b1, 1'b1, 2'd0, 64'hAB_7000,     1'b0}, // R6 fetch
        '{64'h9008_5123, 13'd5, 1'b1, 1'b0, 1'b0, 2'd0, 64'h1_0000_5000, 1'b1}, // R1 512K
        '{64'ha07f_fff8, 13'd5, 1'b0, 1'b1, 1'b0, 2'd2, 64'h0,           1'b0}, // R6 priv
        '{64'ha07f_fff8, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 64'hFF_F000,     1'b1}, // R1 4M
        '{64'ha080_0000, 13'd5, 1'b0, 1'b0, 1'b0, 2'd1, 64'h0,           1'b0}, // R7
        '{64'hb000_0010, 13'd5, 1'b0, 1'b0, 1'b0, 2'd2, 64'h0,           1'b0}, // R6 invalid
        '{64'hc000_1234, 13'd5, 1'b0, 1'b0, 1'b0, 2'd1, 64'h0,           1'b0}, // R2 ctx
        '{64'hc000_1234, 13'd7, 1'b0, 1'b0, 1'b0, 2'd0, 64'h88_9000,     1'b1}, // R2
        '{64'hffff_ffff_ffff_f123, 13'd5, 1'b0, 1'b0, 1'b0, 2'd0, 64'h1FF_FFFF_F000, 1'b0} // R4
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [63:0] tg, input logic [63:0] te);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tg; wr_tte = te;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [63:0] a, input logic [12:0] c, input logic w, input logic u, input logic f);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; ctx = c; req_write = w; req_user = u; req_fetch = f;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic check_kind(input logic [1:0] kind, input string req);
        logic [2:0] exp3, act3;
        exp3 = (kind == 2'd0) ? 3'b100 : (kind == 2'd1) ? 3'b010 : 3'b001;
        act3 = {resp_hit, resp_miss, resp_fault};
        check(resp_valid && act3 == exp3, req, 64'(act3), 64'(exp3));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state
        check(!resp_valid, "R12 resp_valid", 64'(resp_valid), 64'h0);
        check(fsr == 4'h0, "R12 fsr", 64'(fsr), 64'h0);
        check(far == 64'h0, "R12 far", far, 64'h0);

        xlate_en = 1'b1;
        // R12 cleared slot faults for ctx 0 page 0
        look(64'h100, 13'd0, 1'b0, 1'b0, 1'b0);
        check_kind(2'd2, "R12 cleared slot");
        check(fsr == 4'h1, "R8 first fault fsr", 64'(fsr), 64'h1);
        check(far == 64'h100, "R8 far", far, 64'h100);
        // R8 overflow
        look(64'h1f00, 13'd0, 1'b1, 1'b1, 1'b0);
        check(fsr == 4'hF, "R8 overflow fsr", 64'(fsr), 64'hF);
        check(far == 64'h1f00, "R8 far second", far, 64'h1f00);
        // R13 clear
        @(negedge clk); stat_clr = 1'b1;
        @(posedge clk); #1 stat_clr = 1'b0;
        check(fsr == 4'h0, "R13 clear", 64'(fsr), 64'h0);
        // R10 idle
        @(posedge clk); #1;
        check(!resp_valid && !resp_hit && !resp_miss && !resp_fault, "R10 idle", 64'(resp_valid), 64'h0);
        // R9 pass-through
        xlate_en = 1'b0;
        look(64'hDEAD_BEEF_1234_5678, 13'd5, 1'b1, 1'b1, 1'b0);
        check(resp_hit && resp_rd && resp_wr && resp_pa == 64'hDEAD_BEEF_1234_5678, "R9 pass", resp_pa, 64'hDEAD_BEEF_1234_5678);
        xlate_en = 1'b1;

        put(0, 64'h4000_0000 | 64'd5, V | 64'h1_2345_6000 | WB);
        put(1, 64'h8001_0000 | 64'd5, V | (64'd1 << 61) | 64'hAB_0000);
        put(2, 64'h9008_0000 | 64'd5, V | (64'd2 << 61) | 64'h1_0003_0000 | WB);
        put(3, 64'ha040_0000 | 64'd5, V | (64'd3 << 61) | 64'hC0_0000 | PB | WB);
        put(4, 64'hb000_0000 | 64'd5, 64'h0);
        put(6, 64'h4000_0000 | 64'd5, V | 64'h77_7000 | WB);
        put(7, 64'hc000_0000 | 64'd7, V | 64'h88_8000 | WB);
        put(8, 64'hffff_ffff_ffff_e000 | 64'd5, V | (64'd1 << 50) | 64'h1FF_FFFF_F000 | 64'hFF8);

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].addr, VECS[i].cx, VECS[i].wr, VECS[i].usr, VECS[i].fch);
            check_kind(VECS[i].kind, $sformatf("R6/R7 vector %0d kind", i));
            check(resp_pa == VECS[i].pa, $sformatf("R4 vector %0d pa", i), resp_pa, VECS[i].pa);
            check(resp_wr == VECS[i].wperm, $sformatf("R5 vector %0d wr", i), 64'(resp_wr), 64'(VECS[i].wperm));
        end

        // R11 same-cycle write and lookup
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd9; wr_tag = 64'hd000_0000 | 64'd5; wr_tte = V | 64'h6000;
        req_valid = 1'b1; req_addr = 64'hd000_0040; ctx = 13'd5; req_write = 1'b0; req_user = 1'b0; req_fetch = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0; req_valid = 1'b0;
        check_kind(2'd1, "R11 old contents");
        look(64'hd000_0040, 13'd5, 1'b0, 1'b0, 1'b0);
        check_kind(2'd0, "R11 new contents");
        check(resp_pa == 64'h6000, "R11 pa", resp_pa, 64'h6000);

        // R13 then R8 fault bits from a clean status; R6 fetch mode no fault
        @(negedge clk); stat_clr = 1'b1;
        @(posedge clk); #1 stat_clr = 1'b0;
        look(64'h8001_0000, 13'd5, 1'b1, 1'b1, 1'b1);
        check_kind(2'd0, "R6 fetch skips write check");
        check(fsr == 4'h0, "R6 fetch leaves fsr", 64'(fsr), 64'h0);
        look(64'h8001_0000, 13'd5, 1'b1, 1'b1, 1'b0);
        check(fsr == 4'hD, "R8 user write fsr", 64'(fsr), 64'hD);
        check(far == 64'h8001_0000, "R8 far capture", far, 64'h8001_0000);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule